// File: doc/BRIEF.md
# Programming-Mode Address Counter

This block is the address pointer and memory-map front end used while a small flash microcontroller is held in its serial programming mode. It keeps a 14-bit program counter that is cleared when programming mode is entered and that can only move forward. It moves forward by one on an increment pulse or jumps to the base of configuration space on a load-configuration pulse. The serial shifter that decodes commands supplies these pulses. The memory arrays are outside the block. The counter turns into three physical addresses: one for the 1K-word user flash, one for the 32-word configuration area and one for the 128-byte data EEPROM. A region code tells the arrays which of them the current command targets.

The counter has two separate wrap domains. In user space the low 13 bits wrap from 0x1FFF to 0x0000. Once configuration space has been entered, bit 13 stays set, so the counter wraps from 0x3FFF to 0x2000 until programming mode is left. The block also filters read data on its way back to the shifter. Protected program words read as zero, except the oscillator calibration word at the top of user flash. Configuration-space words always read through. Data bytes read as zero when data protection is active.

The control core is a three-state machine. OFF means programming mode is inactive. USER means the counter is in user space. CFG means the counter is in configuration space. These are the transitions:
- OFF→USER: entry pulse without an exit pulse.
- USER→CFG: load-configuration pulse.
- USER→OFF and CFG→OFF: exit pulse.
- CFG→CFG: load-configuration pulse, which reloads the base.
- USER→USER and CFG→CFG: increment pulse.
In every other case the state holds.

Top module: `prog_addr_unit`

## Requirements
- R1: An entry pulse while inactive makes the block active with the counter at 0x0000; an entry pulse while active is ignored, so leaving and re-entering is the only way to clear the counter.
- R2: In user space an increment pulse adds one to the counter, and 0x1FFF is followed by 0x0000.
- R3: A load-configuration pulse while active sets the counter to 0x2000, from user space or from configuration space.
- R4: In configuration space an increment pulse adds one, 0x3FFF is followed by 0x2000, and bit 13 stays 1 until an exit pulse.
- R5: Priority is exit, then load-configuration, then increment; an exit pulse clears the counter to 0x0000 and deactivates; increment and load-configuration pulses while inactive have no effect, and an entry pulse together with an exit pulse leaves the block inactive.
- R6: The region output is 0 while inactive, 3 when active with sel_data high, otherwise 1 in user space and 2 in configuration space.
- R7: flash_addr equals counter bits 9:0, cfg_addr equals bits 4:0 and ee_addr equals bits 6:0, so higher addresses alias into the implemented words.
- R8: In region 1 with cfg_word bit 7 low, rdata is zero unless flash_addr is 0x3FF; with bit 7 high rdata equals raw_rdata.
- R9: In region 2, rdata equals raw_rdata whatever the protection bits.
- R10: In region 3, rdata carries raw_rdata bits 7:0 with bits 13:8 zero, and is all zero when cfg_word bit 8 is low.
- R11: After reset and while inactive, the counter is 0x0000, active is low and rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_enter | input | 1 | Single-cycle pulse: programming mode entered |
| mode_exit | input | 1 | Single-cycle pulse: programming mode left |
| inc_strobe | input | 1 | Single-cycle pulse: advance the counter |
| ldcfg_strobe | input | 1 | Single-cycle pulse: jump to configuration base |
| sel_data | input | 1 | Current command addresses the data EEPROM |
| cfg_word | input | 14 | Stored configuration word (bit 7 program protect, bit 8 data protect, both active low) |
| raw_rdata | input | 14 | Read data from the selected array |
| active | output | 1 | Programming mode active |
| region | output | 2 | Target region code |
| pc | output | 14 | Program counter |
| flash_addr | output | 10 | User flash word address |
| cfg_addr | output | 5 | Configuration area word address |
| ee_addr | output | 7 | Data EEPROM byte address |
| rdata | output | 14 | Masked read data |

## Verification
The counter is driven through more than 8192 consecutive increments in each space. This shows whether the user wrap lands on 0x0000 and whether the configuration wrap lands on 0x2000 rather than falling back to user space. Simultaneous pulse combinations are applied: exit with increment, load-configuration with increment, and entry with exit. They separate the priority order from a merely sequential decode, and a repeated entry pulse tells a true re-entry from an ignored one. Read data is random, and the protection bits and sel_data change on every step. This sets calibration-word exemption, always-open configuration reads and byte truncation of data reads apart from plain zeroing.

// File: rtl/prog_addr_pkg.sv
package prog_addr_pkg;

    localparam int PA_PC_W     = 14;
    localparam int PA_FLASH_AW = 10;
    localparam int PA_CFG_AW   = 5;
    localparam int PA_EE_AW    = 7;
    localparam int PA_WORD_W   = 14;
    localparam int PA_EE_DW    = 8;
    localparam int PA_CP_BIT   = 7;
    localparam int PA_CPD_BIT  = 8;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_USER = 2'd1,
        ST_CFG  = 2'd2
    } pa_state_e;

    typedef enum logic [1:0] {
        RG_NONE   = 2'd0,
        RG_FLASH  = 2'd1,
        RG_CONFIG = 2'd2,
        RG_DATA   = 2'd3
    } pa_region_e;

endpackage

// File: rtl/pa_counter.sv
module pa_counter
    import prog_addr_pkg::*;
#(
    parameter int PC_W = PA_PC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter,
    input  logic            leave,
    input  logic            inc,
    input  logic            ldcfg,
    output pa_state_e       st,
    output logic [PC_W-1:0] pc
);
    localparam int LOW_W = PC_W - 1;
    localparam logic [PC_W-1:0] CFG_BASE = {1'b1, {LOW_W{1'b0}}};

    pa_state_e       st_q, st_d;
    logic [PC_W-1:0] pc_q, pc_d;
    logic [LOW_W-1:0] low_next;

    assign low_next = pc_q[LOW_W-1:0] + LOW_W'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
            pc_q <= '0;
        end else begin
            st_q <= st_d;
            pc_q <= pc_d;
        end
    end

    // transitions and counter updates
    always_comb begin
        st_d = st_q;
        pc_d = pc_q;
        unique case (st_q)
            ST_OFF: begin
                if (enter && !leave) begin
                    st_d = ST_USER;
                    pc_d = '0;
                end
            end
            ST_USER: begin
                if (leave) begin
                    st_d = ST_OFF;
                    pc_d = '0;
                end else if (ldcfg) begin
                    st_d = ST_CFG;
                    pc_d = CFG_BASE;
                end else if (inc) begin
                    pc_d = {1'b0, low_next};
                end
            end
            ST_CFG: begin
                if (leave) begin
                    st_d = ST_OFF;
                    pc_d = '0;
                end else if (ldcfg) begin
                    pc_d = CFG_BASE;
                end else if (inc) begin
                    pc_d = {1'b1, low_next};
                end
            end
            default: begin
                st_d = ST_OFF;
                pc_d = '0;
            end
        endcase
    end

    assign st = st_q;
    assign pc = pc_q;
endmodule

// File: rtl/pa_decode.sv
module pa_decode
    import prog_addr_pkg::*;
#(
    parameter int PC_W     = PA_PC_W,
    parameter int FLASH_AW = PA_FLASH_AW,
    parameter int CFG_AW   = PA_CFG_AW,
    parameter int EE_AW    = PA_EE_AW
) (
    input  pa_state_e           st,
    input  logic [PC_W-1:0]     pc,
    input  logic                sel_data,
    output pa_region_e          region,
    output logic [FLASH_AW-1:0] flash_addr,
    output logic [CFG_AW-1:0]   cfg_addr,
    output logic [EE_AW-1:0]    ee_addr
);
    always_comb begin
        unique case (st)
            ST_OFF:  region = RG_NONE;
            ST_USER: region = sel_data ? RG_DATA : RG_FLASH;
            ST_CFG:  region = sel_data ? RG_DATA : RG_CONFIG;
            default: region = RG_NONE;
        endcase
    end

    // aliasing: each array decodes only its own low bits
    assign flash_addr = pc[FLASH_AW-1:0];
    assign cfg_addr   = pc[CFG_AW-1:0];
    assign ee_addr    = pc[EE_AW-1:0];
endmodule

// File: rtl/pa_readmask.sv
module pa_readmask
    import prog_addr_pkg::*;
#(
    parameter int WORD_W   = PA_WORD_W,
    parameter int EE_DW    = PA_EE_DW,
    parameter int FLASH_AW = PA_FLASH_AW,
    parameter int CP_BIT   = PA_CP_BIT,
    parameter int CPD_BIT  = PA_CPD_BIT
) (
    input  pa_region_e          region,
    input  logic [FLASH_AW-1:0] flash_addr,
    input  logic [WORD_W-1:0]   cfg_word,
    input  logic [WORD_W-1:0]   raw,
    output logic [WORD_W-1:0]   rdata
);
    logic prog_locked, data_locked, cal_word;
    logic pass_flash, pass_cfg, pass_data;

    assign prog_locked = !cfg_word[CP_BIT];
    assign data_locked = !cfg_word[CPD_BIT];
    assign cal_word    = &flash_addr;

    assign pass_flash = (region == RG_FLASH) && (!prog_locked || cal_word);
    assign pass_cfg   = (region == RG_CONFIG);
    assign pass_data  = (region == RG_DATA) && !data_locked;

    for (genvar b = 0; b < WORD_W; b++) begin : g_lane
        if (b < EE_DW) begin : g_byte
            assign rdata[b] = raw[b] & (pass_flash | pass_cfg | pass_data);
        end else begin : g_upper
            assign rdata[b] = raw[b] & (pass_flash | pass_cfg);
        end
    end
endmodule

// File: rtl/prog_addr_unit.sv
module prog_addr_unit
    import prog_addr_pkg::*;
#(
    parameter int PC_W     = PA_PC_W,
    parameter int FLASH_AW = PA_FLASH_AW,
    parameter int CFG_AW   = PA_CFG_AW,
    parameter int EE_AW    = PA_EE_AW,
    parameter int WORD_W   = PA_WORD_W,
    parameter int EE_DW    = PA_EE_DW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_enter,
    input  logic                mode_exit,
    input  logic                inc_strobe,
    input  logic                ldcfg_strobe,
    input  logic                sel_data,
    input  logic [WORD_W-1:0]   cfg_word,
    input  logic [WORD_W-1:0]   raw_rdata,
    output logic                active,
    output logic [1:0]          region,
    output logic [PC_W-1:0]     pc,
    output logic [FLASH_AW-1:0] flash_addr,
    output logic [CFG_AW-1:0]   cfg_addr,
    output logic [EE_AW-1:0]    ee_addr,
    output logic [WORD_W-1:0]   rdata
);
    pa_state_e  st;
    pa_region_e rg;

    pa_counter #(.PC_W(PC_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .enter (mode_enter),
        .leave (mode_exit),
        .inc   (inc_strobe),
        .ldcfg (ldcfg_strobe),
        .st    (st),
        .pc    (pc)
    );

    pa_decode #(
        .PC_W(PC_W), .FLASH_AW(FLASH_AW), .CFG_AW(CFG_AW), .EE_AW(EE_AW)
    ) u_dec (
        .st         (st),
        .pc         (pc),
        .sel_data   (sel_data),
        .region     (rg),
        .flash_addr (flash_addr),
        .cfg_addr   (cfg_addr),
        .ee_addr    (ee_addr)
    );

    pa_readmask #(
        .WORD_W(WORD_W), .EE_DW(EE_DW), .FLASH_AW(FLASH_AW)
    ) u_mask (
        .region     (rg),
        .flash_addr (flash_addr),
        .cfg_word   (cfg_word),
        .raw        (raw_rdata),
        .rdata      (rdata)
    );

    assign active = (st != ST_OFF);
    assign region = rg;
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
    parameter int PC_W    = 14,
    parameter int WORD_W  = 14,
    parameter int CPD_BIT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_enter,
    input logic              mode_exit,
    input logic              inc_strobe,
    input logic              ldcfg_strobe,
    input logic [WORD_W-1:0] cfg_word,
    input logic              active,
    input logic [1:0]        region,
    input logic [PC_W-1:0]   pc,
    input logic [WORD_W-1:0] rdata
);
    localparam logic [PC_W-1:0] CFG_BASE = {1'b1, {(PC_W-1){1'b0}}};
    localparam logic [PC_W-1:0] LOW_MASK = {1'b0, {(PC_W-1){1'b1}}};

    assert_entry_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && mode_enter && !mode_exit) |=> (active && pc == '0));

    assert_user_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !pc[PC_W-1] && inc_strobe && !ldcfg_strobe && !mode_exit)
        |=> (pc == (($past(pc) + PC_W'(1)) & LOW_MASK)));

    assert_ldcfg_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ldcfg_strobe && !mode_exit) |=> (pc == CFG_BASE));

    assert_cfg_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc[PC_W-1] && !mode_exit) |=> pc[PC_W-1]);

    assert_exit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_exit |=> (!active && pc == '0));

    assert_pc_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_enter && !mode_exit && !inc_strobe && !ldcfg_strobe) |=> $stable(pc));

    assert_data_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (region == 2'd3 && !cfg_word[CPD_BIT]) |-> (rdata == '0));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (pc == '0 && rdata == '0 && region == 2'd0));
endmodule

bind prog_addr_unit pa_checker #(.PC_W(PC_W), .WORD_W(WORD_W), .CPD_BIT(8)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_enter   (mode_enter),
    .mode_exit    (mode_exit),
    .inc_strobe   (inc_strobe),
    .ldcfg_strobe (ldcfg_strobe),
    .cfg_word     (cfg_word),
    .active       (active),
    .region       (region),
    .pc           (pc),
    .rdata        (rdata)
);

// File: tb/tb_prog_addr_unit.sv
module tb_prog_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_enter = 0, mode_exit = 0, inc_strobe = 0, ldcfg_strobe = 0, sel_data = 0;
    logic [13:0] cfg_word = 14'h3FFF, raw_rdata = '0;
    logic        active;
    logic [1:0]  region;
    logic [13:0] pc, rdata;
    logic [9:0]  flash_addr;
    logic [4:0]  cfg_addr;
    logic [6:0]  ee_addr;

    int n_chk = 0, n_fail = 0;
    int m_act = 0, m_pc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    prog_addr_unit dut (
        .clk(clk), .rst_n(rst_n), .mode_enter(mode_enter), .mode_exit(mode_exit),
        .inc_strobe(inc_strobe), .ldcfg_strobe(ldcfg_strobe), .sel_data(sel_data),
        .cfg_word(cfg_word), .raw_rdata(raw_rdata), .active(active), .region(region),
        .pc(pc), .flash_addr(flash_addr), .cfg_addr(cfg_addr), .ee_addr(ee_addr),
        .rdata(rdata)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
        end
    endtask

    function automatic int exp_region();
        if (!m_act) return 0;
        if (sel_data) return 3;
        return (m_pc >= 'h2000) ? 2 : 1;
    endfunction

    function automatic int exp_rdata();
        int rg = exp_region();
        if (rg == 0) return 0;
        if (rg == 3) return cfg_word[8] ? (int'(raw_rdata) % 256) : 0;
        if (rg == 2) return int'(raw_rdata);
        if (cfg_word[7] || (m_pc % 1024) == 1023) return int'(raw_rdata);
        return 0;
    endfunction

    task automatic check_all();
        cmp("R11/R1 active", int'(active), m_act);
        cmp("R2/R3/R4 pc", int'(pc), m_pc);
        cmp("R6 region", int'(region), exp_region());
        cmp("R7 flash_addr", int'(flash_addr), m_pc % 1024);
        cmp("R7 cfg_addr", int'(cfg_addr), m_pc % 32);
        cmp("R7 ee_addr", int'(ee_addr), m_pc % 128);
        cmp("R8/R9/R10 rdata", int'(rdata), exp_rdata());
    endtask

    // one clock: check current outputs, apply new inputs, advance the model
    task automatic step(input bit en, input bit ex, input bit in, input bit ld);
        @(negedge clk);
        check_all();
        mode_enter = en; mode_exit = ex; inc_strobe = in; ldcfg_strobe = ld;
        sel_data = ($urandom % 4) == 0;
        cfg_word = 14'($urandom);
        raw_rdata = 14'($urandom);
        @(posedge clk);
        if (ex) begin
            m_act = 0; m_pc = 0;
        end else if (!m_act) begin
            if (en) begin m_act = 1; m_pc = 0; end
        end else if (ld) begin
            m_pc = 'h2000;
        end else if (in) begin
            if (m_pc >= 'h2000) m_pc = 'h2000 + ((m_pc + 1 - 'h2000) % 'h2000);
            else m_pc = (m_pc + 1) % 'h2000;
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all();                              // R11 reset state
        rst_n = 1'b1;
        step(0, 0, 1, 0); step(0, 0, 0, 1);       // R5 strobes while inactive
        step(1, 1, 0, 0);                         // R5 enter with exit
        step(0, 0, 0, 0);
        step(1, 0, 0, 0);                         // R1 enter
        step(0, 0, 1, 0); step(0, 0, 1, 0);
        step(1, 0, 0, 0);                         // R1 enter while active ignored
        for (int i = 0; i < 8300; i++) step(0, 0, 1, 0);   // R2 wrap, R8 calibration
        step(0, 1, 1, 0);                         // R5 exit beats increment
        step(1, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0);
        step(0, 0, 1, 1);                         // R3/R5 load beats increment
        for (int i = 0; i < 8300; i++) step(0, 0, 1, 0);   // R4 wrap to base
        step(0, 0, 0, 1);                         // R3 reload inside config space
        step(0, 0, 1, 0);
        step(0, 1, 0, 1);                         // R5 exit beats load
        step(1, 0, 0, 0);                         // R1 re-entry clears
        for (int i = 0; i < 3000; i++)
            step(($urandom % 64) == 0, ($urandom % 128) == 0,
                 ($urandom % 2) == 0, ($urandom % 32) == 0);
        step(0, 0, 0, 0);
        @(negedge clk);
        check_all();
        done = 1;
        report();
    end
endmodule